// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds the enable state and the pending state of 32 interrupt request lines, and it exposes both through a small word-wide register window. Each state vector has two write addresses. A write to the set address turns on every bit written as 1. A write to the clear address turns off every bit written as 1. Bits written as 0 are left alone. Software can therefore change one line without a read-modify-write, which could lose a concurrent change to a different bit.

Request inputs are sampled on every clock. A line marked as an edge line in the `LEVEL_MASK` parameter latches pending on a rising edge, so a pulse only one cycle wide is still captured. A level line is also pending for as long as its input stays high. Pending state is recorded whether or not the line is enabled. The `req_out` vector carries the lines that are both enabled and pending to a downstream selector. That selector returns an acknowledge carrying a line index, and the acknowledge clears the serviced line's pending bit. The acknowledge is a valid-only transfer with no back-pressure: the block accepts it in every cycle. The register bus is also always ready, and read data is combinational from the address.

Top module: `irq_bank`

## Requirements
- R1: After reset, the enable vector, the pending vector and `req_out` are all zero.
- R2: A write to offset 0x000 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Reads of 0x000 and of 0x080 both return the enable vector.
- R3: A write to offset 0x080 clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to offset 0x100 sets, and a write to offset 0x180 clears, each pending bit whose write-data bit is 1. Reads of 0x100 and of 0x180 both return the pending vector. Bit n of every register belongs to line n.
- R5: `req_out` bit n is 1 exactly when enable bit n and pending bit n are both 1. A disabled line still becomes pending.
- R6: On an edge line (the `LEVEL_MASK` bit is 0), a rising edge of `irq_in`, including a pulse one cycle wide, sets the pending bit at the next clock edge. The bit stays set after the input falls, until it is cleared.
- R7: On a level line (the `LEVEL_MASK` bit is 1), the pending bit sets while the input is high. If an acknowledge clears the bit while the input is still high, the bit is 0 for one cycle and is 1 again one clock later.
- R8: An acknowledge (`ack_valid`=1 with `ack_idx`=n) clears pending bit n at that clock edge and leaves every other pending bit unchanged.
- R9: If a rising request edge or a set-pending write for a line arrives in the same cycle as a clear-pending write or an acknowledge for that line, the pending bit ends up set.
- R10: Writes to any offset other than the four listed are ignored. This includes offsets that are not multiples of 4. Reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | 32 | Raw request lines |
| ack_valid | input | 1 | Service acknowledge, accepted in every cycle |
| ack_idx | input | 5 | Index of the line being serviced |
| req_out | output | 32 | Lines that are both enabled and pending |

## Verification
The bench builds the block with `LEVEL_MASK` = 32'h00FF00FF. This places level lines and edge lines in both halves of the word, so the random phase exercises the two trigger styles side by side and both interact with acknowledges and clear writes. With that mix, the following are all reached within a few thousand cycles:
- a level line re-arming after an acknowledge;
- an edge pulse landing on the same cycle as an acknowledge;
- a set-pending write colliding with an acknowledge;
- writes to unmapped and misaligned offsets.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int LINES  = 32;
  localparam int IDX_W  = $clog2(LINES);
  localparam int ADDR_W = 10;

  localparam logic [ADDR_W-1:0] OFS_EN_SET = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 10'h080;
  localparam logic [ADDR_W-1:0] OFS_PD_SET = 10'h100;
  localparam logic [ADDR_W-1:0] OFS_PD_CLR = 10'h180;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_PD_SET,
    SEL_PD_CLR
  } win_sel_e;

  function automatic win_sel_e win_decode(input logic [ADDR_W-1:0] a);
    win_sel_e s;
    case (a)
      OFS_EN_SET: s = SEL_EN_SET;
      OFS_EN_CLR: s = SEL_EN_CLR;
      OFS_PD_SET: s = SEL_PD_SET;
      OFS_PD_CLR: s = SEL_PD_CLR;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_bank_pkg::*;
(
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  input  logic [LINES-1:0]  en_q,
  input  logic [LINES-1:0]  pend_q,
  output logic [LINES-1:0]  en_set,
  output logic [LINES-1:0]  en_clr,
  output logic [LINES-1:0]  pd_set,
  output logic [LINES-1:0]  pd_clr,
  output logic [LINES-1:0]  bus_rdata
);
  win_sel_e sel;

  always_comb begin
    sel    = win_decode(bus_addr);
    en_set = '0;
    en_clr = '0;
    pd_set = '0;
    pd_clr = '0;
    if (bus_wr) begin
      case (sel)
        SEL_EN_SET: en_set = bus_wdata;
        SEL_EN_CLR: en_clr = bus_wdata;
        SEL_PD_SET: pd_set = bus_wdata;
        SEL_PD_CLR: pd_clr = bus_wdata;
        default: ;
      endcase
    end
    case (sel)
      SEL_EN_SET, SEL_EN_CLR: bus_rdata = en_q;
      SEL_PD_SET, SEL_PD_CLR: bus_rdata = pend_q;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_bank_pkg::*;
#(
  parameter logic [LINES-1:0] LEVEL_MASK = 32'h0000FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] clr_vec,
  output logic [LINES-1:0] hw_set
);
  logic [LINES-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (LEVEL_MASK[i]) begin : g_level
      // a rising edge always sets; a held level yields to a clear for one cycle
      assign hw_set[i] = irq_in[i] & (~irq_q[i] | ~clr_vec[i]);
    end else begin : g_edge
      assign hw_set[i] = irq_in[i] & ~irq_q[i];
    end
  end
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] en_set,
  input  logic [LINES-1:0] en_clr,
  input  logic [LINES-1:0] pd_set,
  input  logic [LINES-1:0] pd_clr,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_set | (en_q & ~en_clr);
      pend_q <= pd_set | (pend_q & ~pd_clr);
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter logic [LINES-1:0] LEVEL_MASK = 32'h0000FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  irq_in,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [LINES-1:0]  req_out
);
  logic [LINES-1:0] en_q, pend_q;
  logic [LINES-1:0] en_set, en_clr, sw_pd_set, sw_pd_clr;
  logic [LINES-1:0] ack_vec, hw_set, pd_set_all, pd_clr_all;

  always_comb begin
    for (int i = 0; i < LINES; i++)
      ack_vec[i] = ack_valid && (ack_idx == IDX_W'(i));
  end

  assign pd_clr_all = sw_pd_clr | ack_vec;
  assign pd_set_all = sw_pd_set | hw_set;

  irq_regwin u_win (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .pd_set    (sw_pd_set),
    .pd_clr    (sw_pd_clr),
    .bus_rdata (bus_rdata)
  );

  irq_capture #(.LEVEL_MASK(LEVEL_MASK)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .clr_vec (pd_clr_all),
    .hw_set  (hw_set)
  );

  irq_state u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_set (en_set),
    .en_clr (en_clr),
    .pd_set (pd_set_all),
    .pd_clr (pd_clr_all),
    .en_q   (en_q),
    .pend_q (pend_q)
  );

  assign req_out = en_q & pend_q;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
  import irq_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  bus_rdata,
  input logic [LINES-1:0]  irq_in,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  ack_idx,
  input logic [LINES-1:0]  req_out,
  input logic [LINES-1:0]  en_q,
  input logic [LINES-1:0]  pend_q
);
  logic [LINES-1:0] irq_prev, rise, swset;
  logic unmapped;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_prev <= '0;
    else        irq_prev <= irq_in;
  end

  assign rise     = irq_in & ~irq_prev;
  assign swset    = (bus_wr && bus_addr == OFS_PD_SET) ? bus_wdata : '0;
  assign unmapped = !(bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR ||
                      bus_addr == OFS_PD_SET || bus_addr == OFS_PD_CLR);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && pend_q == '0 && req_out == '0));

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0));

  // R6
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !rise[ack_idx] && !swset[ack_idx]) |=> !pend_q[$past(ack_idx)]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (rise[ack_idx] || swset[ack_idx])) |=> pend_q[$past(ack_idx)]);

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> $stable(en_q));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));
endmodule

bind irq_bank irq_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_in    (irq_in),
  .ack_valid (ack_valid),
  .ack_idx   (ack_idx),
  .req_out   (req_out),
  .en_q      (en_q),
  .pend_q    (pend_q)
);

// File: tb/tb_irq_bank.sv
`timescale 1ns/1ps
module tb_irq_bank;
  localparam logic [31:0] LVL = 32'h00FF00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_idx = '0;
  logic [31:0] req_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_en = '0, m_pend = '0, m_irqq = '0;

  always #2 clk = ~clk;

  irq_bank #(.LEVEL_MASK(LVL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .req_out(req_out)
  );

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    if (a == 10'h000 || a == 10'h080) return m_en;
    if (a == 10'h100 || a == 10'h180) return m_pend;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: advance model from driven inputs, then sample after the edge
  task automatic cycle();
    logic [31:0] wv, clr, hw, ackv;
    wv   = bus_wr ? bus_wdata : 32'h0;
    ackv = ack_valid ? (32'h1 << ack_idx) : 32'h0;
    clr  = ackv | ((bus_addr == 10'h180) ? wv : 32'h0);
    hw   = (irq_in & ~m_irqq) | (irq_in & LVL & ~clr);
    @(posedge clk);
    #1;
    if (rst_n) begin
      m_pend = ((bus_addr == 10'h100) ? wv : 32'h0) | hw | (m_pend & ~clr);
      m_en   = ((bus_addr == 10'h000) ? wv : 32'h0) |
               (m_en & ~((bus_addr == 10'h080) ? wv : 32'h0));
      m_irqq = irq_in;
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cycle();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();

    // R1 reset state
    chk("R1 req_out", req_out, 32'h0);
    rd(10'h000, d); chk("R1 enable", d, 32'h0);
    rd(10'h100, d); chk("R1 pending", d, 32'h0);

    // R2 set-enable, both read aliases
    wr(10'h000, 32'h0000_0005);
    rd(10'h080, d); chk("R2 read clear alias", d, 32'h0000_0005);
    wr(10'h000, 32'h0000_0100);
    rd(10'h000, d); chk("R2 zero bits kept", d, 32'h0000_0105);

    // R3 clear-enable
    wr(10'h080, 32'h0000_0004);
    rd(10'h000, d); chk("R3 clear one bit", d, 32'h0000_0101);

    // R4 set/clear pending
    wr(10'h100, 32'h0001_0100);
    rd(10'h180, d); chk("R4 set pending", d, 32'h0001_0100);
    wr(10'h180, 32'h0000_0100);
    rd(10'h100, d); chk("R4 clear pending", d, 32'h0001_0000);

    // R5 gating by enable
    chk("R5 disabled pending hidden", req_out, 32'h0);
    wr(10'h000, 32'h0001_0000);
    chk("R5 enabled pending shown", req_out, 32'h0001_0000);

    // R6 one-cycle pulse on edge line 30, line disabled
    irq_in = 32'h4000_0000; cycle();
    irq_in = 32'h0; cycle(); cycle(); cycle();
    rd(10'h100, d); chk("R6 pulse latched", d, 32'h4001_0000);
    chk("R5 disabled line not presented", req_out, 32'h0001_0000);

    // R8 acknowledge line 30 clears only it
    ack_valid = 1'b1; ack_idx = 5'd30; cycle(); ack_valid = 1'b0;
    rd(10'h100, d); chk("R8 ack clears one", d, 32'h0001_0000);

    // R7 level line 2 re-arms after ack
    irq_in = 32'h0000_0004; cycle();
    rd(10'h100, d); chk("R7 level sets", d, 32'h0001_0004);
    ack_valid = 1'b1; ack_idx = 5'd2; cycle(); ack_valid = 1'b0;
    rd(10'h100, d); chk("R7 cleared by ack", d, 32'h0001_0000);
    cycle();
    rd(10'h100, d); chk("R7 re-set while held", d, 32'h0001_0004);
    irq_in = 32'h0; ack_valid = 1'b1; ack_idx = 5'd2; cycle(); ack_valid = 1'b0;
    cycle();
    rd(10'h100, d); chk("R7 stays clear after drop", d, 32'h0001_0000);

    // R9 edge on line 25 in same cycle as ack
    wr(10'h100, 32'h0200_0000);
    irq_in = 32'h0200_0000; ack_valid = 1'b1; ack_idx = 5'd25; cycle();
    ack_valid = 1'b0; irq_in = 32'h0;
    rd(10'h100, d); chk("R9 edge beats ack", d, 32'h0201_0000);
    // R9 set-pending write with ack on line 26
    ack_valid = 1'b1; ack_idx = 5'd26;
    wr(10'h100, 32'h0400_0000); ack_valid = 1'b0;
    rd(10'h100, d); chk("R9 write beats ack", d, 32'h0601_0000);

    // R10 unmapped and misaligned offsets
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h200, 32'hFFFF_FFFF);
    wr(10'h082, 32'hFFFF_FFFF);
    rd(10'h000, d); chk("R10 enable untouched", d, 32'h0001_0101);
    rd(10'h180, d); chk("R10 pending untouched", d, 32'h0601_0000);
    rd(10'h004, d); chk("R10 unmapped read", d, 32'h0);
    rd(10'h101, d); chk("R10 misaligned read", d, 32'h0);

    // random mix checked against the bench model
    for (int k = 0; k < 4000; k++) begin
      int sel;
      irq_in    = $urandom & $urandom & $urandom;
      ack_valid = ($urandom % 4) == 0;
      ack_idx   = 5'($urandom);
      bus_wr    = ($urandom % 3) == 0;
      sel       = $urandom % 6;
      case (sel)
        0: bus_addr = 10'h000;
        1: bus_addr = 10'h080;
        2: bus_addr = 10'h100;
        3: bus_addr = 10'h180;
        default: bus_addr = 10'($urandom);
      endcase
      bus_wdata = $urandom & $urandom;
      cycle();
      chk("R5 random req_out", req_out, m_en & m_pend);
      chk("R4 random read", bus_rdata, exp_read(bus_addr));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule